// File: doc/BRIEF.md
# Multiplexed Port Register Window

This block lets one processor core reach several physical 32-bit pin ports through a single set of four port registers. It does not dedicate a register to every port. A select operation chooses which port the window points at. After that, reads and writes at the window addresses reach only that port's input pins and its output, direction and alternate-mode latches. There are three full 32-pin ports, numbered 0 to 2. Port 3 has only its top byte.

A pin-wait unit is attached to the same selection. It masks the selected port's inputs each clock and compares the result against a target, in either an equal or a not-equal sense. It stops on the first hit. If a non-zero cycle budget was given, it also stops when that budget runs out. The outcome is reported on a carry output: 1 for a timeout, 0 for a pin hit.

Top module: `port_window`

## Requirements
- R1: After reset the active port is 0, every output, direction and alternate latch of every port is 0, `wait_busy` is 0 and `wait_carry` is 0.
- R2: With `sel_valid` high and `sel_from_reg` low, `sel_value` is the port number, and any value above 3 selects port 3. The new port applies from the cycle after the select. A read in the select cycle still returns data from the previously selected port.
- R3: With `sel_valid` and `sel_from_reg` high, the port number is `sel_value >> 4`, again clamped to 3.
- R4: Register reads are combinational, and these four addresses of a 9-bit space raise `reg_hit`:
  - 0x1FC returns the selected port's input pins and is read-only, so writes there change nothing.
  - 0x1FD is the output latch.
  - 0x1FE is the direction latch.
  - 0x1FF is the alternate-mode latch.
  - Every other address reads 0 with `reg_hit` low, and writes to it are ignored.
- R5: A write reaches only the selected port's latch. The latches of every other port keep their values.
- R6: In port 3, bits 31:24 exist and bits 23:0 do not. Reads return 0 in bits 23:0 for every register, including the input. Writes to those bits are dropped, and the matching pins on `pin_out`, `pin_dir` and `pin_alt` stay 0.
- R7: A wait starts on the clock edge where `wait_start` is high and no wait is running. From the next cycle, the unit tests `(pins & wait_mask) == wait_target` on every cycle. When `wait_ne` is 1 the test is inverted. After the first cycle where the test holds, `wait_done` pulses for one cycle, `wait_busy` falls and `wait_carry` is 0. A test that already holds when the wait starts gives `wait_done` one cycle after the start edge.
- R8: With a timeout T > 0 and no hit, the wait ends after T compare cycles with `wait_carry` = 1. `wait_done` is then visible T cycles after the start edge.
- R9: A timeout of 0 waits without limit, and a wait of this kind always ends with `wait_carry` = 0.
- R10: `wait_start` is ignored while a wait is running.
- R11: A running wait compares whichever port is selected in each cycle, so a port selection made during the wait redirects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_valid | input | 1 | Port select strobe |
| sel_from_reg | input | 1 | 1: value is a pin number (port in bits 4 and up); 0: value is the port number |
| sel_value | input | 32 | Port number or pin number |
| reg_addr | input | 9 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| reg_hit | output | 1 | Address falls in the port window |
| pin_in | input | 128 | Pin inputs, port p at bits [32p+31:32p] |
| pin_out | output | 128 | Output latches of all ports |
| pin_dir | output | 128 | Direction latches of all ports |
| pin_alt | output | 128 | Alternate-mode latches of all ports |
| wait_start | input | 1 | Start a pin wait |
| wait_ne | input | 1 | 1: wait until not equal; 0: wait until equal |
| wait_mask | input | 32 | Compare mask |
| wait_target | input | 32 | Compare target |
| wait_timeout | input | 32 | Cycle budget; 0 waits without limit |
| wait_busy | output | 1 | Wait in progress |
| wait_done | output | 1 | One-cycle completion pulse |
| wait_carry | output | 1 | 1 if the last wait timed out |

## Verification
The assertions check several properties on every cycle:
- The selection holds when no select is issued, and large immediates clamp to port 3.
- Latches whose write strobe is low keep their value, and a write to the input address leaves every latch untouched.
- A wait becomes busy after its start and ignores restarts while running.
- A completion only follows a busy cycle, a timeout carry only follows budget expiry, and an unlimited wait never reports carry.

Only the bench scenarios can show the rest:
- The one-cycle delay of a selection against a same-cycle read.
- The exact completion latency for matches and for several budgets.
- The bit masking of the partial port.
- That a wait follows a selection made while it runs.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  localparam int PORT_W = 32;

  typedef enum logic [1:0] {
    RK_IN  = 2'd0,
    RK_OUT = 2'd1,
    RK_DIR = 2'd2,
    RK_ALT = 2'd3
  } reg_kind_e;

  // Saturate a requested port number to the last existing port.
  function automatic logic [31:0] clamp_port(input logic [31:0] v, input logic [31:0] nports);
    if (v > nports - 32'd1) return nports - 32'd1;
    return v;
  endfunction

  // Masked pin test, inverted for the not-equal sense.
  function automatic logic pin_cond(input logic [PORT_W-1:0] pins,
                                    input logic [PORT_W-1:0] mask,
                                    input logic [PORT_W-1:0] target,
                                    input logic want_ne);
    return ((pins & mask) == target) ^ want_ne;
  endfunction

  // Bits that physically exist in a port whose lowest pin is lsb.
  function automatic logic [PORT_W-1:0] exist_mask(input int lsb);
    logic [PORT_W-1:0] m;
    for (int i = 0; i < PORT_W; i++) m[i] = (i >= lsb);
    return m;
  endfunction
endpackage

// File: rtl/pwin_sel.sv
module pwin_sel
  import pwin_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PIN_SHIFT = 4,
  localparam int PSEL_W = $clog2(NUM_PORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_valid,
  input  logic              sel_from_reg,
  input  logic [31:0]       sel_value,
  output logic [PSEL_W-1:0] active_port
);
  logic [31:0] raw_port;
  logic [31:0] clamped;

  assign raw_port = sel_from_reg ? (sel_value >> PIN_SHIFT) : sel_value;
  assign clamped  = clamp_port(raw_port, NUM_PORTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active_port <= '0;
    else if (sel_valid) active_port <= clamped[PSEL_W-1:0];
  end

  // R2: selection only changes on a select strobe
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |=> $stable(active_port));
  // R2: oversized immediate lands on the last port
  p_sel_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_from_reg && sel_value >= NUM_PORTS) |=> (active_port == PSEL_W'(NUM_PORTS-1)));
endmodule

// File: rtl/pwin_bank.sv
module pwin_bank
  import pwin_pkg::*;
#(
  parameter int EXIST_LSB = 0,
  localparam int W = PORT_W - EXIST_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        we,      // [0] out, [1] dir, [2] alt
  input  logic [W-1:0]      wdata,
  output logic [PORT_W-1:0] out_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] alt_q
);
  logic [W-1:0] lat [3];

  for (genvar k = 0; k < 3; k++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lat[k] <= '0;
      else if (we[k]) lat[k] <= wdata;
    end
    // R5: a latch without its strobe keeps its value
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !we[k] |=> $stable(lat[k]));
  end

  if (EXIST_LSB > 0) begin : g_partial
    assign out_q = {lat[0], {EXIST_LSB{1'b0}}};
    assign dir_q = {lat[1], {EXIST_LSB{1'b0}}};
    assign alt_q = {lat[2], {EXIST_LSB{1'b0}}};
  end else begin : g_full
    assign out_q = lat[0];
    assign dir_q = lat[1];
    assign alt_q = lat[2];
  end
endmodule

// File: rtl/pwin_wait.sv
module pwin_wait
  import pwin_pkg::*;
#(
  parameter int TMO_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              want_ne,
  input  logic [PORT_W-1:0] mask,
  input  logic [PORT_W-1:0] target,
  input  logic [TMO_W-1:0]  timeout,
  input  logic [PORT_W-1:0] port_pins,
  output logic              busy,
  output logic              done,
  output logic              carry
);
  logic              ne_q, forever_q;
  logic [PORT_W-1:0] mask_q, tgt_q;
  logic [TMO_W-1:0]  cnt_q;
  logic              hit, expire;

  assign hit    = busy && pin_cond(port_pins, mask_q, tgt_q, ne_q);
  assign expire = busy && !forever_q && (cnt_q == TMO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; carry <= 1'b0;
      ne_q <= 1'b0; forever_q <= 1'b0;
      mask_q <= '0; tgt_q <= '0; cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          ne_q      <= want_ne;
          mask_q    <= mask;
          tgt_q     <= target;
          cnt_q     <= timeout;
          forever_q <= (timeout == '0);
        end
      end else if (hit) begin
        busy <= 1'b0; done <= 1'b1; carry <= 1'b0;
      end else if (expire) begin
        busy <= 1'b0; done <= 1'b1; carry <= 1'b1;
      end else if (!forever_q) begin
        cnt_q <= cnt_q - TMO_W'(1);
      end
    end
  end

  // R7: an accepted start makes the unit busy
  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R7: completion only directly after a busy cycle
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R8: carry only rises on budget expiry
  p_carry_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carry) |-> $past(expire));
  // R9: unlimited wait never ends with carry
  p_forever_nocarry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(forever_q)) |-> !carry);
  // R10: a running wait keeps its operands despite new starts
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hit && !expire) |=> (busy && $stable(mask_q) && $stable(tgt_q) && $stable(ne_q)));
endmodule

// File: rtl/port_window.sv
module port_window
  import pwin_pkg::*;
#(
  parameter int          NUM_PORTS   = 4,
  parameter int          PIN_SHIFT   = 4,
  parameter int          PARTIAL_LSB = 24,
  parameter int          ADDR_W      = 9,
  parameter logic [8:0]  WIN_BASE    = 9'h1FC,
  parameter int          TMO_W       = 32,
  localparam int         PSEL_W      = $clog2(NUM_PORTS),
  localparam int         ALL_W       = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_valid,
  input  logic              sel_from_reg,
  input  logic [31:0]       sel_value,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_hit,
  input  logic [ALL_W-1:0]  pin_in,
  output logic [ALL_W-1:0]  pin_out,
  output logic [ALL_W-1:0]  pin_dir,
  output logic [ALL_W-1:0]  pin_alt,
  input  logic              wait_start,
  input  logic              wait_ne,
  input  logic [31:0]       wait_mask,
  input  logic [31:0]       wait_target,
  input  logic [TMO_W-1:0]  wait_timeout,
  output logic              wait_busy,
  output logic              wait_done,
  output logic              wait_carry
);
  logic [PSEL_W-1:0] active_port;
  reg_kind_e         kind;
  logic [PORT_W-1:0] in_m  [NUM_PORTS];
  logic [PORT_W-1:0] out_a [NUM_PORTS];
  logic [PORT_W-1:0] dir_a [NUM_PORTS];
  logic [PORT_W-1:0] alt_a [NUM_PORTS];
  logic              wr_hit;

  pwin_sel #(.NUM_PORTS(NUM_PORTS), .PIN_SHIFT(PIN_SHIFT)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_from_reg(sel_from_reg),
    .sel_value(sel_value), .active_port(active_port));

  assign reg_hit = (reg_addr[ADDR_W-1:2] == WIN_BASE[ADDR_W-1:2]);
  assign kind    = reg_kind_e'(reg_addr[1:0]);
  assign wr_hit  = reg_wr && reg_hit && (kind != RK_IN);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int LSB = (p == NUM_PORTS - 1) ? PARTIAL_LSB : 0;
    logic [2:0] we;
    logic       mine;

    assign mine  = wr_hit && (active_port == PSEL_W'(p));
    assign we[0] = mine && (kind == RK_OUT);
    assign we[1] = mine && (kind == RK_DIR);
    assign we[2] = mine && (kind == RK_ALT);
    assign in_m[p] = pin_in[p*PORT_W +: PORT_W] & exist_mask(LSB);

    pwin_bank #(.EXIST_LSB(LSB)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(we), .wdata(reg_wdata[PORT_W-1:LSB]),
      .out_q(out_a[p]), .dir_q(dir_a[p]), .alt_q(alt_a[p]));

    assign pin_out[p*PORT_W +: PORT_W] = out_a[p];
    assign pin_dir[p*PORT_W +: PORT_W] = dir_a[p];
    assign pin_alt[p*PORT_W +: PORT_W] = alt_a[p];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_hit) begin
      unique case (kind)
        RK_IN:   reg_rdata = in_m[active_port];
        RK_OUT:  reg_rdata = out_a[active_port];
        RK_DIR:  reg_rdata = dir_a[active_port];
        RK_ALT:  reg_rdata = alt_a[active_port];
        default: reg_rdata = '0;
      endcase
    end
  end

  pwin_wait #(.TMO_W(TMO_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .start(wait_start), .want_ne(wait_ne),
    .mask(wait_mask), .target(wait_target), .timeout(wait_timeout),
    .port_pins(in_m[active_port]), .busy(wait_busy), .done(wait_done), .carry(wait_carry));

  // R4: a write aimed at the input address alters no latch
  p_in_readonly_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_hit && kind == RK_IN) |=> ($stable(pin_out) && $stable(pin_dir) && $stable(pin_alt)));
  // R4: writes outside the window alter no latch
  p_miss_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_hit) |=> ($stable(pin_out) && $stable(pin_dir) && $stable(pin_alt)));
endmodule

// File: tb/tb_port_window.sv
module tb_port_window;
  localparam int CLK_PERIOD = 10;

  typedef struct { string req; logic [31:0] exp; } item_t;
  item_t sb[$];
  int n_run = 0, n_fail = 0;

  logic clk = 0, rst_n = 0;
  logic sel_valid = 0, sel_from_reg = 0;
  logic [31:0] sel_value = 0;
  logic [8:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic reg_hit;
  logic [127:0] pin_in = 0, pin_out, pin_dir, pin_alt;
  logic wait_start = 0, wait_ne = 0;
  logic [31:0] wait_mask = 0, wait_target = 0, wait_timeout = 0;
  logic wait_busy, wait_done, wait_carry;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_window dut (.*);

  task automatic expect_val(string r, logic [31:0] e);
    item_t it; it.req = r; it.exp = e; sb.push_back(it);
  endtask

  task automatic monitor_pop(logic [31:0] act);
    item_t it = sb.pop_front();
    n_run++;
    if (act !== it.exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
    end
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] e);
    expect_val(r, e); monitor_pop(act);
  endtask

  task automatic rd(string r, logic [8:0] a, logic [31:0] e);
    reg_addr = a; expect_val(r, e); #1 monitor_pop(reg_rdata);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic sel(logic fromreg, logic [31:0] v);
    @(negedge clk); sel_valid = 1; sel_from_reg = fromreg; sel_value = v;
    @(negedge clk); sel_valid = 0;
  endtask

  task automatic start_wait(logic ne, logic [31:0] m, logic [31:0] t, logic [31:0] tmo);
    @(negedge clk); wait_start = 1; wait_ne = ne; wait_mask = m; wait_target = t; wait_timeout = tmo;
    @(negedge clk); wait_start = 0;
  endtask

  task automatic cycles_to_done(output int n, input int limit);
    n = 0;
    while (!wait_done && n < limit) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    pin_in[0 +: 32]  = 32'h1234_5678;
    pin_in[32 +: 32] = 32'h0BAD_F00D;
    pin_in[64 +: 32] = 32'h0000_0000;
    pin_in[96 +: 32] = 32'hABCD_EF12;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out all", 32'(|pin_out), 0);
    chk("R1 dir/alt all", 32'(|{pin_dir, pin_alt}), 0);
    chk("R1 busy/carry", {30'd0, wait_busy, wait_carry}, 0);
    rd("R1 port0 out", 9'h1FD, 0);
    // R4 map
    wr(9'h1FD, 32'hA5A5_0001);
    wr(9'h1FE, 32'h0000_FF00);
    wr(9'h1FF, 32'h8000_0003);
    rd("R4 out", 9'h1FD, 32'hA5A5_0001);
    rd("R4 dir", 9'h1FE, 32'h0000_FF00);
    rd("R4 alt", 9'h1FF, 32'h8000_0003);
    rd("R4 in", 9'h1FC, 32'h1234_5678);
    wr(9'h1FC, 32'hFFFF_FFFF);
    rd("R4 in read-only", 9'h1FD, 32'hA5A5_0001);
    chk("R4 in read-only pins", pin_dir[31:0], 32'h0000_FF00);
    wr(9'h1FA, 32'h5555_5555);
    reg_addr = 9'h1FA; #1 chk("R4 miss hit", 32'(reg_hit), 0);
    rd("R4 miss read zero", 9'h1FB, 0);
    chk("R4 miss write ignored", pin_out[31:0], 32'hA5A5_0001);
    // R2 late select
    @(negedge clk); sel_valid = 1; sel_from_reg = 0; sel_value = 2;
    rd("R2 same-cycle old port", 9'h1FD, 32'hA5A5_0001);
    @(negedge clk); sel_valid = 0;
    rd("R2 new port", 9'h1FD, 0);
    wr(9'h1FD, 32'hDEAD_BEEF);
    chk("R5 port2 pins", pin_out[64 +: 32], 32'hDEAD_BEEF);
    chk("R5 port0 untouched", pin_out[0 +: 32], 32'hA5A5_0001);
    chk("R5 port1 untouched", pin_out[32 +: 32], 0);
    // R2 clamp, R6 partial port
    sel(0, 9);
    wr(9'h1FD, 32'hFFFF_FFFF);
    rd("R6 port3 out", 9'h1FD, 32'hFF00_0000);
    chk("R6 port3 pins", pin_out[96 +: 32], 32'hFF00_0000);
    rd("R6 port3 in", 9'h1FC, 32'hAB00_0000);
    chk("R5 port2 kept", pin_out[64 +: 32], 32'hDEAD_BEEF);
    // R3 pin-number select
    sel(1, 32'h15);
    rd("R3 pin 21 -> port1", 9'h1FC, 32'h0BAD_F00D);
    sel(1, 32'h7F);
    rd("R3 clamp -> port3", 9'h1FC, 32'hAB00_0000);
    // Waits on port 0
    sel(0, 0);
    start_wait(0, 32'h0000_FFFF, 32'h0000_5678, 50);
    cycles_to_done(n, 100);
    chk("R7 eq immediate latency", n, 1);
    chk("R7 eq carry", 32'(wait_carry), 0);
    start_wait(1, 32'h0000_FFFF, 32'h0000_5678, 4);
    cycles_to_done(n, 100);
    chk("R8 ne timeout latency", n, 4);
    chk("R8 ne timeout carry", 32'(wait_carry), 1);
    start_wait(1, 32'h0000_FFFF, 32'h0000_0000, 50);
    cycles_to_done(n, 100);
    chk("R7 ne hit latency", n, 1);
    chk("R7 ne hit carry", 32'(wait_carry), 0);
    start_wait(0, 32'h0000_FFFF, 32'h0000_1111, 7);
    cycles_to_done(n, 100);
    chk("R8 T=7 latency", n, 7);
    chk("R8 T=7 carry", 32'(wait_carry), 1);
    // R9 / R10 unlimited wait, restart ignored
    start_wait(0, 32'h0000_FFFF, 32'h0000_1111, 0);
    repeat (5) @(negedge clk);
    start_wait(0, 32'h0000_FFFF, 32'h0000_5678, 2);
    repeat (25) @(negedge clk);
    chk("R9 R10 still busy", 32'(wait_busy), 1);
    pin_in[15:0] = 16'h1111;
    cycles_to_done(n, 100);
    chk("R9 hit after pin change", n, 1);
    chk("R9 carry zero", 32'(wait_carry), 0);
    // R11 wait follows selection
    start_wait(0, 32'h0000_FFFF, 32'h0000_CAFE, 0);
    pin_in[64 +: 16] = 16'hCAFE;
    repeat (3) @(negedge clk);
    chk("R11 busy before reselect", 32'(wait_busy), 1);
    @(negedge clk); sel_valid = 1; sel_from_reg = 0; sel_value = 2;
    @(negedge clk); sel_valid = 0;
    cycles_to_done(n, 100);
    chk("R11 done after reselect", n, 1);
    chk("R11 carry", 32'(wait_carry), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule